// File: doc/BRIEF.md
# Windowed Watchdog with Keyed Service

This block is a supervisory timer. A counter climbs from zero towards a timeout value. If software does not service it in time, the block raises a one-cycle reset request for the chip's reset controller. Software services the timer by writing two key bytes in a row to a service port: first 0x55, then 0xAA.

A write-once configuration port sets two things: the count source and the window mode. The count source is either a slow 1 kHz strobe or every bus clock. In window mode a service is accepted only in the last quarter of the timeout period. Any write to the service port before that point is treated as a fault and forces an immediate reset request. Window mode takes effect only while the bus clock is the count source.

Top module: `wdog_window`

## Requirements
- R1: After reset `rst_req` is low, the count is zero, the 1 kHz strobe is the source and normal mode applies, so with no strobe no request ever appears.
- R2: With source select 0 the count advances only on clocks where `tick_1k` is high; the request follows the clock edge carrying the TIMEOUT-th strobe.
- R3: With source select 1 the count advances on every clock; a request is high in the cycle after the TIMEOUT-th edge and lasts one cycle.
- R4: After a request the count restarts from zero, so the next expiry comes TIMEOUT edges later.
- R5: A service is a write of 0x55 followed, on the next service write, by 0xAA; it clears the count and the key tracker.
- R6: 0xAA without a directly preceding 0x55, or any other value, returns the tracker to idle with no service; in normal mode this is never a fault.
- R7: In window mode any service write while the count is below the boundary (3*TIMEOUT/4) gives a request in the next cycle and restarts the count.
- R8: In window mode writes with the count at or above the boundary are not faults, and a 0x55/0xAA pair there services the timer.
- R9: Window mode is in force only when source select is 1; with the strobe source the block acts in normal mode even if window enable is set.
- R10: Only the first configuration write after reset takes effect; later writes change neither source nor mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1k | input | 1 | One-clock strobe from the slow 1 kHz source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bus_clk | input | 1 | Source select: 0 strobe, 1 bus clock |
| cfg_window | input | 1 | Window mode enable |
| svc_we | input | 1 | Service port write strobe |
| svc_data | input | 8 | Service port write data |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench counts edges from a known point and drives the count with three patterns. With no strobe, the count must stay at zero. With a sparse strobe, the count must advance only on strobed edges. With the bus clock, it must advance on every edge. These patterns show whether the source select is obeyed. Key traffic covers the valid pair, a lone 0xAA, a foreign byte between the keys, and a foreign byte inside the open window. Each of these must be told apart by whether the next expiry moves. Window writes placed one count below and exactly at the boundary locate the boundary. Repeating the same early writes with the strobe source, or after a rejected second configuration write, shows that window mode and the write-once lock are both in force.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef enum logic {KEY_IDLE, KEY_ARMED} key_state_t;

  // first count value at which servicing is allowed in window mode
  function automatic int win_start(input int timeout);
    return (3 * timeout) / 4;
  endfunction

  // next key tracker state for one service write
  function automatic key_state_t key_next(input key_state_t cur,
                                          input logic [7:0] data);
    if (data == KEY_FIRST) return KEY_ARMED;
    return KEY_IDLE;
  endfunction
endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_bus_clk,
  input  logic cfg_window,
  output logic src_bus,
  output logic win_en
);
  logic locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked  <= 1'b0;
      src_bus <= 1'b0;
      win_en  <= 1'b0;
    end else if (cfg_we && !locked) begin
      locked  <= 1'b1;
      src_bus <= cfg_bus_clk;
      win_en  <= cfg_window;
    end
  end

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(src_bus) && $stable(win_en) && locked));
endmodule

// File: rtl/wdog_key.sv
module wdog_key
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] data,
  input  logic       abort,
  output logic       done,
  output logic       armed
);
  key_state_t state;

  assign armed = (state == KEY_ARMED);
  assign done  = wr && armed && (data == KEY_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state <= KEY_IDLE;
    else if (abort)    state <= KEY_IDLE;
    else if (wr)       state <= key_next(state, data);
  end

  // R5
  key_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !armed);
  // R6
  key_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && data != KEY_FIRST) |=> !armed);
endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt #(
  parameter int TIMEOUT = 1024,
  localparam int CW = $clog2(TIMEOUT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          clear,
  output logic [CW-1:0] cnt,
  output logic          at_end
);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  assign at_end = advance && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clear)    cnt <= '0;
    else if (advance)  cnt <= cnt + 1'b1;
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !clear) |=> $stable(cnt));
  // R4
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));
endmodule

// File: rtl/wdog_window.sv
module wdog_window
  import wdog_pkg::*;
#(
  parameter int TIMEOUT = 1024,
  localparam int CW = $clog2(TIMEOUT)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1k,
  input  logic       cfg_we,
  input  logic       cfg_bus_clk,
  input  logic       cfg_window,
  input  logic       svc_we,
  input  logic [7:0] svc_data,
  output logic       rst_req
);
  localparam logic [CW-1:0] WIN_B = CW'(win_start(TIMEOUT));

  logic          src_bus, win_en, win_active;
  logic          advance, at_end, key_done, key_armed;
  logic          early_fault, service, expire, fire;
  logic [CW-1:0] cnt;

  wdog_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_bus_clk(cfg_bus_clk), .cfg_window(cfg_window),
    .src_bus(src_bus), .win_en(win_en)
  );

  assign win_active  = src_bus && win_en;
  assign advance     = src_bus ? 1'b1 : tick_1k;
  assign early_fault = win_active && svc_we && (cnt < WIN_B);
  assign service     = key_done && !early_fault;
  assign expire      = at_end && !service;
  assign fire        = early_fault || expire;

  wdog_key u_key (
    .clk(clk), .rst_n(rst_n), .wr(svc_we), .data(svc_data),
    .abort(fire), .done(key_done), .armed(key_armed)
  );

  wdog_cnt #(.TIMEOUT(TIMEOUT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .advance(advance),
    .clear(fire || service), .cnt(cnt), .at_end(at_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= fire;
  end

  // R7
  early_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    early_fault |=> rst_req);
  // R9
  win_needs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !src_bus |-> !early_fault);
  // R5
  service_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (service && !early_fault) |=> (!rst_req && cnt == '0));
  // R8
  open_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_we && cnt >= WIN_B && !at_end) |=> !rst_req);
endmodule

// File: tb/wdog_window_test.sv
module wdog_window_test;
  localparam int PER = 10;
  localparam int T   = 16;
  localparam int WB  = (T * 3) / 4;

  logic clk = 1'b0, rst_n = 1'b0, tick_1k = 1'b0;
  logic cfg_we = 1'b0, cfg_bus_clk = 1'b0, cfg_window = 1'b0;
  logic svc_we = 1'b0;
  logic [7:0] svc_data = 8'h00;
  logic rst_req;
  int checks = 0, fails = 0, k = 0;
  bit done = 1'b0;

  always #(PER/2) clk = ~clk;

  wdog_window #(.TIMEOUT(T)) uut (
    .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .cfg_we(cfg_we),
    .cfg_bus_clk(cfg_bus_clk), .cfg_window(cfg_window),
    .svc_we(svc_we), .svc_data(svc_data), .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s edge=%0d rst_req=%b expected=%b", req, k, act, exp);
    end
  endtask

  task automatic reset_dut();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    k = 0;
  endtask

  task automatic cfg(input logic s, input logic w);
    cfg_we = 1'b1; cfg_bus_clk = s; cfg_window = w;
    @(negedge clk);
    cfg_we = 1'b0;
    k = 0;
  endtask

  // one clock: drive at negedge, result sampled at the next negedge
  task automatic cyc(input logic we, input logic [7:0] d, input logic tk,
                     input string req, input logic exp);
    svc_we = we; svc_data = d; tick_1k = tk;
    @(negedge clk);
    k++;
    svc_we = 1'b0; tick_1k = 1'b0;
    chk(req, rst_req, exp);
  endtask

  task automatic idle_to(input int last, input int pulse_at, input logic tk,
                         input string req);
    while (k < last) cyc(1'b0, 8'h00, tk, req, (k + 1) == pulse_at);
  endtask

  task automatic t_reset_and_tick();
    reset_dut();
    chk("R1", rst_req, 1'b0);
    idle_to(40, -1, 1'b0, "R1");
    for (int i = 1; i <= T; i++) begin
      cyc(1'b0, 8'h00, 1'b0, "R2", 1'b0);
      cyc(1'b0, 8'h00, 1'b0, "R2", 1'b0);
      cyc(1'b0, 8'h00, 1'b1, "R2", i == T);
    end
    cyc(1'b0, 8'h00, 1'b0, "R3", 1'b0);
  endtask

  task automatic t_bus_expire();
    reset_dut(); cfg(1'b1, 1'b0);
    idle_to(T, T, 1'b0, "R3");
    idle_to(2 * T + 1, 2 * T, 1'b0, "R4");
  endtask

  task automatic t_service();
    reset_dut(); cfg(1'b1, 1'b0);
    idle_to(4, -1, 1'b0, "R5");
    cyc(1'b1, 8'h55, 1'b0, "R5", 1'b0);
    cyc(1'b1, 8'hAA, 1'b0, "R5", 1'b0);
    idle_to(6 + T, 6 + T, 1'b0, "R5");
  endtask

  task automatic t_bad_keys();
    reset_dut(); cfg(1'b1, 1'b0);
    idle_to(2, -1, 1'b0, "R6");
    cyc(1'b1, 8'hAA, 1'b0, "R6", 1'b0);
    cyc(1'b1, 8'h55, 1'b0, "R6", 1'b0);
    cyc(1'b1, 8'h12, 1'b0, "R6", 1'b0);
    cyc(1'b1, 8'hAA, 1'b0, "R6", 1'b0);
    idle_to(T, T, 1'b0, "R6");
  endtask

  task automatic t_window_early();
    reset_dut(); cfg(1'b1, 1'b1);
    idle_to(WB - 1, -1, 1'b0, "R7");
    cyc(1'b1, 8'h55, 1'b0, "R7", 1'b1);   // count WB-1 at this edge
    idle_to(WB + T, WB + T, 1'b0, "R7");
  endtask

  task automatic t_window_ok();
    reset_dut(); cfg(1'b1, 1'b1);
    idle_to(WB, -1, 1'b0, "R8");
    cyc(1'b1, 8'h12, 1'b0, "R8", 1'b0);   // count WB: open, foreign byte
    cyc(1'b1, 8'h55, 1'b0, "R8", 1'b0);
    cyc(1'b1, 8'hAA, 1'b0, "R8", 1'b0);
    idle_to(WB + 3 + T, WB + 3 + T, 1'b0, "R8");
  endtask

  task automatic t_window_needs_bus();
    reset_dut(); cfg(1'b0, 1'b1);
    idle_to(2, -1, 1'b1, "R9");
    cyc(1'b1, 8'h55, 1'b1, "R9", 1'b0);
    cyc(1'b1, 8'hAA, 1'b1, "R9", 1'b0);
    idle_to(4 + T, 4 + T, 1'b1, "R9");
  endtask

  task automatic t_write_once();
    reset_dut(); cfg(1'b1, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, "R10", 1'b0);
    cfg_we = 1'b1; cfg_bus_clk = 1'b0; cfg_window = 1'b1;
    @(negedge clk); k++;
    cfg_we = 1'b0;
    chk("R10", rst_req, 1'b0);
    idle_to(4, -1, 1'b0, "R10");
    cyc(1'b1, 8'h55, 1'b0, "R10", 1'b0);
    cyc(1'b1, 8'hAA, 1'b0, "R10", 1'b0);
    idle_to(6 + T, 6 + T, 1'b0, "R10");
  endtask

  initial begin
    t_reset_and_tick();
    t_bus_expire();
    t_service();
    t_bad_keys();
    t_window_early();
    t_window_ok();
    t_window_needs_bus();
    t_write_once();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(PER * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule